// File: doc/BRIEF.md
# PAM3 Three-Bit to Two-Symbol Mapper

This block sits between the scrambler and the line-facing symbol path of a gigabit single-pair PHY. It has two independent directions. On the transmit side each 3-bit group from the scrambled stream becomes one pair of ternary symbols. One pair is two symbol slots on the line, so the mapper does one conversion every two slots. On the receive side, pairs of ternary symbols that an upstream aligner has already placed on frame boundaries are turned back into 3-bit groups. The one pair that no group maps to is reported as invalid.

A frame holds 4050 bits, which is 2700 symbols or 1350 pairs. Each direction tracks its place in the frame. It marks the pair that carries the frame's first symbol and the pair that carries its last symbol. On transmit the position runs freely from reset. On receive it is restarted by a start marker that arrives with the incoming pair. Each direction has a valid/ready handshake on both sides and a one-entry output slot. The slot is a two-state machine: SLOT_EMPTY and SLOT_FULL. The transitions are:
- SLOT_EMPTY to SLOT_FULL when an input is accepted.
- SLOT_FULL to SLOT_FULL when the output is taken and a new input is accepted in the same cycle, or when the output is stalled.
- SLOT_FULL to SLOT_EMPTY when the output is taken and no new input arrives.

Top module: `pam3_mapper`

## Requirements
- R1: After reset both output valids are 0 and both input readies are 1.
- R2: Symbol codes are 2-bit two's complement: 2'b11 = -1, 2'b00 = 0, 2'b01 = +1. Group value v (0..7) maps to pair index k = v for v < 4 and k = v + 1 otherwise. Symbol A (sent first) is k/3 - 1 and symbol B is k%3 - 1. The transmitter therefore never sends the pair (0,0).
- R3: Each accepted transmit group gives exactly one output pair, valid in the cycle after acceptance. A pair that is stalled (valid with ready low) stays unchanged.
- R4: The transmit start marker is 1 on the first pair after reset and on every 1350th pair after it. The transmit end marker is 1 on the pair just before each start (position 1349).
- R5: Receiving any pair produced under R2 returns its 3-bit value with the invalid flag at 0, one cycle after acceptance.
- R6: Receiving the pair (0,0) sets the invalid flag and outputs 3'b000.
- R7: Receiving the code 2'b10 in either symbol sets the invalid flag and outputs 3'b000.
- R8: A receive pair that comes in with the start marker is frame position 0. The receive start output is 1 at position 0 and the end output is 1 at position 1349. The position wraps to 0 on its own after 1349.
- R9: While an output slot is full and its downstream ready is 0, the input ready of that direction is 0 and the held result is not overwritten.
- R10: The transmitter never drives the symbol code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit group valid |
| tx_in_ready | output | 1 | Transmit group accepted when high |
| tx_in_bits | input | 3 | Transmit 3-bit group |
| tx_out_valid | output | 1 | Transmit symbol pair valid |
| tx_out_ready | input | 1 | Downstream takes the transmit pair |
| tx_sym_a | output | 2 | First transmit symbol |
| tx_sym_b | output | 2 | Second transmit symbol |
| tx_sof | output | 1 | Pair carries frame symbol 0 |
| tx_eof | output | 1 | Pair carries frame symbol 2699 |
| rx_in_valid | input | 1 | Receive pair valid |
| rx_in_ready | output | 1 | Receive pair accepted when high |
| rx_sym_a | input | 2 | First received symbol |
| rx_sym_b | input | 2 | Second received symbol |
| rx_in_sof | input | 1 | Received pair starts a frame |
| rx_out_valid | output | 1 | Receive group valid |
| rx_out_ready | input | 1 | Downstream takes the receive group |
| rx_bits | output | 3 | Recovered 3-bit group |
| rx_inv | output | 1 | Received pair was not a legal code |
| rx_sof | output | 1 | Group is at frame position 0 |
| rx_eof | output | 1 | Group is at frame position 1349 |

## Verification
Every result in both directions is due exactly one clock after the rising edge that completes its input handshake. The only exception is a stalled result, which stays in place until downstream ready returns. The bench drives inputs on the falling edge and checks outputs on the next falling edge, which is half a period after the accepting rising edge. For the stall cases it looks at several falling edges in a row to confirm the held pair and the low input ready. The frame tests stream pairs back to back. Each output's position is worked out in the bench from the number of pairs sent since reset, or since the last start marker, so the check on the end marker at position 1349 and on the wrap back to the start marker lands on the correct cycle.

// File: rtl/pam3_map_pkg.sv
package pam3_map_pkg;

    localparam int unsigned GROUP_BITS    = 3;
    localparam int unsigned SYM_W         = 2;
    localparam int          ZERO_PAIR_IDX = 4;

    typedef logic [SYM_W-1:0]      tsym_t;
    typedef logic [GROUP_BITS-1:0] group_t;

    localparam tsym_t SYM_NEG  = 2'b11;
    localparam tsym_t SYM_ZERO = 2'b00;
    localparam tsym_t SYM_POS  = 2'b01;
    localparam tsym_t SYM_BAD  = 2'b10;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef struct packed {
        tsym_t first;
        tsym_t second;
    } sym_pair_t;

    typedef struct packed {
        logic   bad;
        group_t bits;
    } demap_t;

    function automatic tsym_t level_to_sym(input int lvl);
        if (lvl < 0)       return SYM_NEG;
        else if (lvl == 0) return SYM_ZERO;
        else               return SYM_POS;
    endfunction

    // 0,1,2 for -1,0,+1; 3 marks an illegal code
    function automatic int sym_to_index(input tsym_t s);
        int idx;
        case (s)
            SYM_NEG:  idx = 0;
            SYM_ZERO: idx = 1;
            SYM_POS:  idx = 2;
            default:  idx = 3;
        endcase
        return idx;
    endfunction

    function automatic sym_pair_t map_group(input group_t g);
        sym_pair_t p;
        int k;
        k = int'(g);
        if (k >= ZERO_PAIR_IDX) k = k + 1;
        p.first  = level_to_sym(k / 3 - 1);
        p.second = level_to_sym(k % 3 - 1);
        return p;
    endfunction

    function automatic demap_t demap_pair(input tsym_t a, input tsym_t b);
        demap_t r;
        int ia;
        int ib;
        int k;
        ia     = sym_to_index(a);
        ib     = sym_to_index(b);
        r.bad  = 1'b0;
        r.bits = '0;
        if (ia > 2 || ib > 2) begin
            r.bad = 1'b1;
        end else begin
            k = ia * 3 + ib;
            if (k == ZERO_PAIR_IDX)     r.bad  = 1'b1;
            else if (k < ZERO_PAIR_IDX) r.bits = group_t'(k);
            else                        r.bits = group_t'(k - 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pam3_frame_pos.sv
module pam3_frame_pos #(
    parameter int unsigned PAIRS = 1350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic restart,
    output logic first,
    output logic last
);
    localparam int unsigned CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(PAIRS - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cur;
    logic [CW-1:0] nxt;

    always_comb begin
        cur   = restart ? '0 : cnt;
        first = (cur == '0);
        last  = (cur == LAST_POS);
        nxt   = last ? '0 : cur + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= nxt;
    end

endmodule

// File: rtl/pam3_tx_map.sv
module pam3_tx_map
    import pam3_map_pkg::*;
#(
    parameter int unsigned PAIRS = 1350
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output logic   in_ready,
    input  group_t in_bits,
    output logic   out_valid,
    input  logic   out_ready,
    output tsym_t  out_sym_a,
    output tsym_t  out_sym_b,
    output logic   out_sof,
    output logic   out_eof
);
    slot_state_e state;
    slot_state_e state_nxt;
    logic        take;
    logic        pos_first;
    logic        pos_last;
    sym_pair_t   pair_nxt;

    assign in_ready = (state == SLOT_EMPTY) || out_ready;
    assign take     = in_valid && in_ready;
    assign pair_nxt = map_group(in_bits);

    pam3_frame_pos #(.PAIRS(PAIRS)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (take),
        .restart (1'b0),
        .first   (pos_first),
        .last    (pos_last)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            SLOT_EMPTY: if (take)                    state_nxt = SLOT_FULL;
            SLOT_FULL:  if (out_ready && !take)      state_nxt = SLOT_EMPTY;
            default:                                 state_nxt = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sym_a <= SYM_ZERO;
            out_sym_b <= SYM_ZERO;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else if (take) begin
            out_sym_a <= pair_nxt.first;
            out_sym_b <= pair_nxt.second;
            out_sof   <= pos_first;
            out_eof   <= pos_last;
        end
    end

    assign out_valid = (state == SLOT_FULL);

endmodule

// File: rtl/pam3_rx_demap.sv
module pam3_rx_demap
    import pam3_map_pkg::*;
#(
    parameter int unsigned PAIRS = 1350
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output logic   in_ready,
    input  tsym_t  in_sym_a,
    input  tsym_t  in_sym_b,
    input  logic   in_sof,
    output logic   out_valid,
    input  logic   out_ready,
    output group_t out_bits,
    output logic   out_inv,
    output logic   out_sof,
    output logic   out_eof
);
    slot_state_e state;
    slot_state_e state_nxt;
    logic        take;
    logic        pos_first;
    logic        pos_last;
    demap_t      dec;

    assign in_ready = (state == SLOT_EMPTY) || out_ready;
    assign take     = in_valid && in_ready;
    assign dec      = demap_pair(in_sym_a, in_sym_b);

    pam3_frame_pos #(.PAIRS(PAIRS)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (take),
        .restart (in_sof),
        .first   (pos_first),
        .last    (pos_last)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            SLOT_EMPTY: if (take)                    state_nxt = SLOT_FULL;
            SLOT_FULL:  if (out_ready && !take)      state_nxt = SLOT_EMPTY;
            default:                                 state_nxt = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bits <= '0;
            out_inv  <= 1'b0;
            out_sof  <= 1'b0;
            out_eof  <= 1'b0;
        end else if (take) begin
            out_bits <= dec.bits;
            out_inv  <= dec.bad;
            out_sof  <= pos_first;
            out_eof  <= pos_last;
        end
    end

    assign out_valid = (state == SLOT_FULL);

endmodule

// File: rtl/pam3_mapper.sv
module pam3_mapper
    import pam3_map_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 4050
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_in_valid,
    output logic       tx_in_ready,
    input  logic [2:0] tx_in_bits,
    output logic       tx_out_valid,
    input  logic       tx_out_ready,
    output logic [1:0] tx_sym_a,
    output logic [1:0] tx_sym_b,
    output logic       tx_sof,
    output logic       tx_eof,
    input  logic       rx_in_valid,
    output logic       rx_in_ready,
    input  logic [1:0] rx_sym_a,
    input  logic [1:0] rx_sym_b,
    input  logic       rx_in_sof,
    output logic       rx_out_valid,
    input  logic       rx_out_ready,
    output logic [2:0] rx_bits,
    output logic       rx_inv,
    output logic       rx_sof,
    output logic       rx_eof
);
    localparam int unsigned FRAME_SYMS = FRAME_BITS / GROUP_BITS * 2;
    localparam int unsigned PAIRS      = FRAME_SYMS / 2;

    pam3_tx_map #(.PAIRS(PAIRS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_in_valid),
        .in_ready  (tx_in_ready),
        .in_bits   (tx_in_bits),
        .out_valid (tx_out_valid),
        .out_ready (tx_out_ready),
        .out_sym_a (tx_sym_a),
        .out_sym_b (tx_sym_b),
        .out_sof   (tx_sof),
        .out_eof   (tx_eof)
    );

    pam3_rx_demap #(.PAIRS(PAIRS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_in_valid),
        .in_ready  (rx_in_ready),
        .in_sym_a  (rx_sym_a),
        .in_sym_b  (rx_sym_b),
        .in_sof    (rx_in_sof),
        .out_valid (rx_out_valid),
        .out_ready (rx_out_ready),
        .out_bits  (rx_bits),
        .out_inv   (rx_inv),
        .out_sof   (rx_sof),
        .out_eof   (rx_eof)
    );

endmodule

// File: rtl/pam3_mapper_chk.sv
module pam3_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_in_valid,
    input logic       tx_in_ready,
    input logic       tx_out_valid,
    input logic       tx_out_ready,
    input logic [1:0] tx_sym_a,
    input logic [1:0] tx_sym_b,
    input logic       tx_sof,
    input logic       tx_eof,
    input logic       rx_in_valid,
    input logic       rx_in_ready,
    input logic       rx_out_valid,
    input logic       rx_out_ready,
    input logic [2:0] rx_bits,
    input logic       rx_inv
);
    p_legal_sym_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> (tx_sym_a != 2'b10 && tx_sym_b != 2'b10));

    p_no_zero_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> !(tx_sym_a == 2'b00 && tx_sym_b == 2'b00));

    p_tx_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_ready) |=> tx_out_valid);

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_ready) |=>
            (tx_out_valid && $stable(tx_sym_a) && $stable(tx_sym_b)));

    p_tx_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_ready) |-> !tx_in_ready);

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_bits) && $stable(rx_inv)));

    p_rx_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_ready) |=> rx_out_valid);

    p_inv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && rx_inv) |-> (rx_bits == 3'b000));

    p_marks_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> !(tx_sof && tx_eof));

endmodule

bind pam3_mapper pam3_mapper_chk u_chk (.*);

// File: tb/pam3_mapper_test.sv
module pam3_mapper_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_in_valid = 1'b0;
    logic       tx_in_ready;
    logic [2:0] tx_in_bits = '0;
    logic       tx_out_valid;
    logic       tx_out_ready = 1'b1;
    logic [1:0] tx_sym_a;
    logic [1:0] tx_sym_b;
    logic       tx_sof;
    logic       tx_eof;
    logic       rx_in_valid = 1'b0;
    logic       rx_in_ready;
    logic [1:0] rx_sym_a = '0;
    logic [1:0] rx_sym_b = '0;
    logic       rx_in_sof = 1'b0;
    logic       rx_out_valid;
    logic       rx_out_ready = 1'b1;
    logic [2:0] rx_bits;
    logic       rx_inv;
    logic       rx_sof;
    logic       rx_eof;

    localparam int PAIRS = 1350;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    int  tx_pos   = 0;   // pairs sent on transmit since reset

    always #10 clk = ~clk;

    pam3_mapper uut (.*);

    // independent reference: A,B symbol codes per group value
    function automatic logic [3:0] ref_pair(input int v);
        case (v)
            0: return 4'b11_11;
            1: return 4'b11_00;
            2: return 4'b11_01;
            3: return 4'b00_11;
            4: return 4'b00_01;
            5: return 4'b01_11;
            6: return 4'b01_00;
            default: return 4'b01_01;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check(tx_out_valid == 1'b0, "R1 tx_out_valid", int'(tx_out_valid), 0);
        check(rx_out_valid == 1'b0, "R1 rx_out_valid", int'(rx_out_valid), 0);
        check(tx_in_ready == 1'b1, "R1 tx_in_ready", int'(tx_in_ready), 1);
        check(rx_in_ready == 1'b1, "R1 rx_in_ready", int'(rx_in_ready), 1);
    endtask

    task automatic t_tx_table();
        for (int v = 0; v < 8; v++) begin
            tx_in_valid = 1'b1;
            tx_in_bits  = 3'(v);
            @(negedge clk);
            check(tx_out_valid, "R3 tx pair due", int'(tx_out_valid), 1);
            check({tx_sym_a, tx_sym_b} == ref_pair(v), "R2 tx map",
                  int'({tx_sym_a, tx_sym_b}), int'(ref_pair(v)));
            check(tx_sof == (tx_pos == 0), "R4 tx sof", int'(tx_sof), int'(tx_pos == 0));
            tx_pos++;
        end
        tx_in_valid = 1'b0;
        @(negedge clk);
        check(!tx_out_valid, "R3 single pair per group", int'(tx_out_valid), 0);
    endtask

    task automatic t_tx_backpressure();
        tx_out_ready = 1'b0;
        tx_in_valid  = 1'b1;
        tx_in_bits   = 3'd5;
        @(negedge clk);
        tx_pos++;
        tx_in_bits = 3'd2;
        check(!tx_in_ready, "R9 ready low when full", int'(tx_in_ready), 0);
        @(negedge clk);
        check({tx_sym_a, tx_sym_b} == ref_pair(5), "R9 held pair kept",
              int'({tx_sym_a, tx_sym_b}), int'(ref_pair(5)));
        check(tx_out_valid && !tx_in_ready, "R3 stalled pair stays", int'(tx_out_valid), 1);
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_pos++;
        check({tx_sym_a, tx_sym_b} == ref_pair(2), "R9 next pair after release",
              int'({tx_sym_a, tx_sym_b}), int'(ref_pair(2)));
        tx_in_valid = 1'b0;
        @(negedge clk);
        check(!tx_out_valid, "R3 slot drains", int'(tx_out_valid), 0);
    endtask

    task automatic t_tx_frame();
        int sent = PAIRS - tx_pos + 3;
        for (int i = 0; i < sent; i++) begin
            int pos = tx_pos % PAIRS;
            tx_in_valid = 1'b1;
            tx_in_bits  = 3'(i % 8);
            @(negedge clk);
            if (pos == 0 || pos == PAIRS - 1 || tx_sof || tx_eof) begin
                check(tx_sof == (pos == 0), "R4 tx sof position", int'(tx_sof), int'(pos == 0));
                check(tx_eof == (pos == PAIRS - 1), "R4 tx eof position",
                      int'(tx_eof), int'(pos == PAIRS - 1));
            end
            tx_pos++;
        end
        tx_in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_send(input logic [1:0] a, input logic [1:0] b, input logic sof);
        rx_in_valid = 1'b1;
        rx_sym_a    = a;
        rx_sym_b    = b;
        rx_in_sof   = sof;
        @(negedge clk);
    endtask

    task automatic t_rx_table();
        for (int v = 0; v < 8; v++) begin
            logic [3:0] p = ref_pair(v);
            rx_send(p[3:2], p[1:0], v == 0);
            check(rx_out_valid && rx_bits == 3'(v), "R5 rx demap", int'(rx_bits), v);
            check(!rx_inv, "R5 rx legal", int'(rx_inv), 0);
            check(rx_sof == (v == 0), "R8 rx sof on marked pair", int'(rx_sof), int'(v == 0));
        end
        rx_in_valid = 1'b0;
        rx_in_sof   = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rx_invalid();
        rx_send(2'b00, 2'b00, 1'b0);
        check(rx_inv && rx_bits == 3'b000, "R6 zero pair flagged", int'({rx_inv, rx_bits}), 8);
        rx_send(2'b10, 2'b01, 1'b0);
        check(rx_inv && rx_bits == 3'b000, "R7 bad code in A", int'({rx_inv, rx_bits}), 8);
        rx_send(2'b11, 2'b10, 1'b0);
        check(rx_inv && rx_bits == 3'b000, "R7 bad code in B", int'({rx_inv, rx_bits}), 8);
        rx_send(2'b01, 2'b00, 1'b0);
        check(!rx_inv && rx_bits == 3'd6, "R5 legal after invalid", int'({rx_inv, rx_bits}), 6);
        rx_in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rx_frame();
        for (int i = 0; i < PAIRS + 2; i++) begin
            rx_send(2'b11, 2'b00, i == 0);
            if (i == 0 || i == PAIRS - 1 || i == PAIRS || rx_sof || rx_eof) begin
                check(rx_sof == (i % PAIRS == 0), "R8 rx sof position",
                      int'(rx_sof), int'(i % PAIRS == 0));
                check(rx_eof == (i == PAIRS - 1), "R8 rx eof position",
                      int'(rx_eof), int'(i == PAIRS - 1));
            end
        end
        rx_send(2'b11, 2'b00, 1'b1);
        check(rx_sof, "R8 rx mid-frame restart", int'(rx_sof), 1);
        rx_send(2'b11, 2'b00, 1'b0);
        check(!rx_sof && !rx_eof, "R8 rx position 1 unmarked", int'({rx_sof, rx_eof}), 0);
        rx_in_valid = 1'b0;
        rx_in_sof   = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_table();
        t_tx_backpressure();
        t_tx_frame();
        t_rx_table();
        t_rx_invalid();
        t_rx_frame();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

endmodule